// File: doc/BRIEF.md
# Two-Way Handshake Holding Register with Parity

This block is an 8-bit port that passes data between two sides, A and B, through one holding register for each direction. A writer loads a register by raising that direction's load strobe while holding its active-low load enable low. Each load raises a "full" flag that the reader watches. The reader takes the data by pulling its active-low output enable low. When it releases that enable (a low-to-high change), the flag drops and the writer knows the slot is free again.

The two directions are not symmetric. On the A-to-B path, the block generates a parity bit from the stored byte and drives it beside the data. On the B-to-A path, the block stores an incoming parity bit with the byte and reports an active-low parity error. Each three-state output is modelled as a data bus plus a drive-enable signal. All strobes and enables are synchronous to one system clock, and the block finds their rising edges against a registered copy of the previous value.

Top module: `bidir_parity_port`

## Requirements
- R1: The A-to-B register stores `a_in` on the first clock in which `ab_ld` is high after being low, provided `ab_ce_n` is low in that cycle. In every other cycle it keeps its value. Holding `ab_ld` high causes no further loads.
- R2: The B-to-A register stores `b_in`, and a 1-bit parity register stores `par_in`, on the first clock in which `ba_ld` is high after being low, provided `ba_ce_n` is low. In every other cycle both keep their values.
- R3: `ab_full` goes high in the clock after an A-to-B load. `ba_full` goes high in the clock after a B-to-A load.
- R4: A low-to-high change of `b_oe_n` clears `ab_full` in the next clock. A low-to-high change of `a_oe_n` clears `ba_full` in the next clock. Without a load or such a change, a flag holds its value.
- R5: When a load and a clearing enable edge for the same flag fall in the same cycle, the flag ends up high.
- R6: While `b_oe_n` is low, `b_out_en` and `par_out_en` are 1 and `b_out` shows the A-to-B register. While `b_oe_n` is high, both enables are 0 and `b_out` and `par_out` read 0.
- R7: While enabled, `par_out` is 1 when the A-to-B register holds an even number of ones (including all zeros) and 0 when the count is odd.
- R8: While `a_oe_n` is low, `a_out_en` is 1 and `a_out` shows the B-to-A register. While `a_oe_n` is high, `a_out_en` is 0 and `a_out` reads 0.
- R9: While `a_oe_n` is low, `err_n` is 1 when the nine stored bits (B-to-A byte plus stored parity bit) hold an odd number of ones, and 0 when they hold an even number. While `a_oe_n` is high, `err_n` is 1.
- R10: A synchronous `rst` clears both data registers, the parity register and both flags. Enables and strobes that are already high when reset is released do not count as rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | A-side data to be stored for B |
| ab_ld | input | 1 | A-to-B load strobe (acts on its rising edge) |
| ab_ce_n | input | 1 | A-to-B load enable, active low |
| b_oe_n | input | 1 | B-side output enable, active low; its release clears `ab_full` |
| b_out | output | 8 | B-side data out |
| b_out_en | output | 1 | Drive enable for `b_out` |
| par_out | output | 1 | Generated parity bit |
| par_out_en | output | 1 | Drive enable for `par_out` |
| ab_full | output | 1 | A-to-B data-ready flag |
| b_in | input | 8 | B-side data to be stored for A |
| par_in | input | 1 | Parity bit arriving with `b_in` |
| ba_ld | input | 1 | B-to-A load strobe (acts on its rising edge) |
| ba_ce_n | input | 1 | B-to-A load enable, active low |
| a_oe_n | input | 1 | A-side output enable, active low; its release clears `ba_full` |
| a_out | output | 8 | A-side data out |
| a_out_en | output | 1 | Drive enable for `a_out` |
| err_n | output | 1 | Parity error, active low |
| ba_full | output | 1 | B-to-A data-ready flag |

## Verification
Directed loads use all-zero, all-one, single-bit and alternating bytes. These separate even-count from odd-count parity and catch bit-order slips. On the B-to-A side they are paired with both values of the incoming parity bit, so a correct check can be told apart from an inverted one.

Separate sequences cover:
- a strobe with the load enable high (load must not happen),
- a strobe held high (must load once),
- a load and a release landing in the same cycle (set must win),
- enables left high across the end of reset (must not count as edges).

A long run of random strobes, enables and data then compares every output with a behavioural model on every clock.

// File: rtl/bidir_parity_port.sv
module bidir_parity_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ab_ld,
  input  logic         ab_ce_n,
  input  logic         b_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  output logic         par_out,
  output logic         par_out_en,
  output logic         ab_full,
  input  logic [W-1:0] b_in,
  input  logic         par_in,
  input  logic         ba_ld,
  input  logic         ba_ce_n,
  input  logic         a_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_out_en,
  output logic         err_n,
  output logic         ba_full
);

  logic [W-1:0] ab_q, ba_q;
  logic         pq;
  logic         ab_ld_h, ba_ld_h, b_oe_h, a_oe_h;

  logic ab_load, ba_load, ab_rel, ba_rel;
  assign ab_load = ab_ld & ~ab_ld_h & ~ab_ce_n;
  assign ba_load = ba_ld & ~ba_ld_h & ~ba_ce_n;
  assign ab_rel  = b_oe_n & ~b_oe_h;
  assign ba_rel  = a_oe_n & ~a_oe_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q    <= '0;
      ba_q    <= '0;
      pq      <= 1'b0;
      ab_full <= 1'b0;
      ba_full <= 1'b0;
      ab_ld_h <= 1'b1;
      ba_ld_h <= 1'b1;
      b_oe_h  <= 1'b1;
      a_oe_h  <= 1'b1;
    end else begin
      ab_ld_h <= ab_ld;
      ba_ld_h <= ba_ld;
      b_oe_h  <= b_oe_n;
      a_oe_h  <= a_oe_n;
      if (ab_load) ab_q <= a_in;
      if (ba_load) begin
        ba_q <= b_in;
        pq   <= par_in;
      end
      ab_full <= ab_load | (ab_full & ~ab_rel);
      ba_full <= ba_load | (ba_full & ~ba_rel);
    end
  end

  assign b_out_en   = ~b_oe_n;
  assign par_out_en = ~b_oe_n;
  assign b_out      = b_out_en ? ab_q : '0;
  assign par_out    = par_out_en & ~(^ab_q);

  assign a_out_en   = ~a_oe_n;
  assign a_out      = a_out_en ? ba_q : '0;
  assign err_n      = a_oe_n | (^{pq, ba_q});

  assert_ab_capture_R1: assert property (@(posedge clk) disable iff (rst)
    ab_load |=> ab_q == $past(a_in));
  assert_ab_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !ab_load |=> $stable(ab_q));
  assert_ba_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ba_load |=> (ba_q == $past(b_in)) && (pq == $past(par_in)));
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    (ab_load |=> ab_full) and (ba_load |=> ba_full));
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (ab_rel && !ab_load) |=> !ab_full);
  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ba_load && !ba_rel) |=> $stable(ba_full));
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (ab_load && ab_rel) |=> ab_full);
  assert_b_off_R6: assert property (@(posedge clk) disable iff (rst)
    b_oe_n |-> (!b_out_en && !par_out_en && b_out == '0));
  assert_a_off_R8: assert property (@(posedge clk) disable iff (rst)
    a_oe_n |-> (!a_out_en && a_out == '0));
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (rst)
    a_oe_n |-> err_n);
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!ab_full && !ba_full && ab_q == '0 && ba_q == '0 && !pq));

endmodule

// File: tb/sim_bidir_parity_port.sv
module sim_bidir_parity_port;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [7:0] a_in, b_in;
  logic ab_ld, ab_ce_n, b_oe_n, ba_ld, ba_ce_n, a_oe_n, par_in;
  logic [7:0] b_out, a_out;
  logic b_out_en, par_out, par_out_en, ab_full, a_out_en, err_n, ba_full;

  bidir_parity_port #(.W(8)) u0 (
    .clk(clk), .rst(rst),
    .a_in(a_in), .ab_ld(ab_ld), .ab_ce_n(ab_ce_n), .b_oe_n(b_oe_n),
    .b_out(b_out), .b_out_en(b_out_en), .par_out(par_out), .par_out_en(par_out_en),
    .ab_full(ab_full),
    .b_in(b_in), .par_in(par_in), .ba_ld(ba_ld), .ba_ce_n(ba_ce_n), .a_oe_n(a_oe_n),
    .a_out(a_out), .a_out_en(a_out_en), .err_n(err_n), .ba_full(ba_full)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int m_ab, m_ba, m_p, m_fr, m_fs;
  int h_abld, h_bald, h_boe, h_aoe;

  always @(posedge clk) begin
    if (rst) begin
      m_ab = 0; m_ba = 0; m_p = 0; m_fr = 0; m_fs = 0;
      h_abld = 1; h_bald = 1; h_boe = 1; h_aoe = 1;
    end else begin
      int la, lb, ca, cb;
      la = (ab_ld && !h_abld && !ab_ce_n) ? 1 : 0;
      lb = (ba_ld && !h_bald && !ba_ce_n) ? 1 : 0;
      ca = (b_oe_n && !h_boe) ? 1 : 0;
      cb = (a_oe_n && !h_aoe) ? 1 : 0;
      if (la) m_ab = a_in;
      if (lb) begin m_ba = b_in; m_p = par_in; end
      if (la) m_fr = 1; else if (ca) m_fr = 0;
      if (lb) m_fs = 1; else if (cb) m_fs = 0;
      h_abld = ab_ld; h_bald = ba_ld; h_boe = b_oe_n; h_aoe = a_oe_n;
    end
    #2;
    if (!rst) begin
      int ones;
      chk(ab_full == m_fr[0], "R3/R4/R5 ab_full", ab_full, m_fr);
      chk(ba_full == m_fs[0], "R3/R4/R5 ba_full", ba_full, m_fs);
      chk(b_out_en == !b_oe_n && par_out_en == !b_oe_n, "R6 b enables", b_out_en, !b_oe_n);
      chk(b_out == (b_oe_n ? 8'h00 : m_ab[7:0]), "R1/R6 b_out", b_out, b_oe_n ? 0 : m_ab);
      chk(par_out == (!b_oe_n && ($countones(m_ab[7:0]) % 2 == 0)), "R7 par_out",
          par_out, !b_oe_n && ($countones(m_ab[7:0]) % 2 == 0));
      chk(a_out_en == !a_oe_n, "R8 a_out_en", a_out_en, !a_oe_n);
      chk(a_out == (a_oe_n ? 8'h00 : m_ba[7:0]), "R2/R8 a_out", a_out, a_oe_n ? 0 : m_ba);
      ones = $countones(m_ba[7:0]) + m_p;
      chk(err_n == (a_oe_n || (ones % 2 == 1)), "R9 err_n", err_n, a_oe_n || (ones % 2 == 1));
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic load_a(input logic [7:0] d);
    @(negedge clk); a_in = d; ab_ce_n = 0; ab_ld = 1;
    @(negedge clk); ab_ld = 0; ab_ce_n = 1;
  endtask

  task automatic load_b(input logic [7:0] d, input logic p);
    @(negedge clk); b_in = d; par_in = p; ba_ce_n = 0; ba_ld = 1;
    @(negedge clk); ba_ld = 0; ba_ce_n = 1;
  endtask

  task automatic pulse_boe();
    @(negedge clk); b_oe_n = 0;
    @(negedge clk); b_oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; a_in = 0; b_in = 0; par_in = 0;
    ab_ld = 1; ba_ld = 1; ab_ce_n = 0; ba_ce_n = 0; b_oe_n = 1; a_oe_n = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R10: strobes held high across reset release cause no load
    chk(ab_full == 0 && ba_full == 0, "R10 flags after reset", {ab_full, ba_full}, 0);
    ab_ld = 0; ba_ld = 0; ab_ce_n = 1; ba_ce_n = 1;
    b_oe_n = 0; a_oe_n = 0;
    @(negedge clk); #1;
    chk(b_out == 8'h00 && a_out == 8'h00, "R10 data after reset", {b_out, a_out}, 0);
    chk(par_out == 1, "R7 zero byte parity", par_out, 1);
    b_oe_n = 1; a_oe_n = 1;
    idle();

    load_a(8'h00); #1;
    chk(ab_full == 1, "R3 ab_full after load", ab_full, 1);
    b_oe_n = 0; #1;
    chk(b_out == 8'h00 && par_out == 1, "R7 all zeros even", par_out, 1);
    @(negedge clk); b_oe_n = 1; @(negedge clk); #1;
    chk(ab_full == 0, "R4 release clears ab_full", ab_full, 0);

    load_a(8'h01); b_oe_n = 0; #1;
    chk(b_out == 8'h01 && par_out == 0, "R7 single one odd", {b_out, par_out}, 9'h002);
    @(negedge clk); b_oe_n = 1;
    load_a(8'hFF); b_oe_n = 0; #1;
    chk(b_out == 8'hFF && par_out == 1, "R7 all ones even", {b_out, par_out}, 9'h1FF);
    @(negedge clk); b_oe_n = 1; @(negedge clk);

    // R1: strobe with enable high does not load
    @(negedge clk); a_in = 8'h5A; ab_ce_n = 1; ab_ld = 1;
    @(negedge clk); ab_ld = 0; b_oe_n = 0; #1;
    chk(b_out == 8'hFF && ab_full == 0, "R1 no load with enable high", b_out, 8'hFF);
    b_oe_n = 1;

    // R1: held strobe loads once
    @(negedge clk); a_in = 8'hA5; ab_ce_n = 0; ab_ld = 1;
    @(negedge clk); a_in = 8'h3C;
    @(negedge clk); b_oe_n = 0; #1;
    chk(b_out == 8'hA5, "R1 held strobe loads once", b_out, 8'hA5);
    ab_ld = 0; ab_ce_n = 1;
    @(negedge clk);
    // R5: load and release in the same cycle
    a_in = 8'h77; ab_ce_n = 0; ab_ld = 1; b_oe_n = 1;
    @(negedge clk); #1;
    chk(ab_full == 1, "R5 set wins over clear", ab_full, 1);
    ab_ld = 0; ab_ce_n = 1;

    // B-to-A path
    load_b(8'h03, 1'b1); a_oe_n = 0; #1;
    chk(a_out == 8'h03 && err_n == 1, "R9 three ones odd no error", err_n, 1);
    chk(ba_full == 1, "R3 ba_full after load", ba_full, 1);
    @(negedge clk); a_oe_n = 1; #1;
    chk(err_n == 1 && a_out_en == 0, "R8/R9 disabled outputs", {a_out_en, err_n}, 1);
    @(negedge clk); #1;
    chk(ba_full == 0, "R4 release clears ba_full", ba_full, 0);
    load_b(8'h03, 1'b0); a_oe_n = 0; #1;
    chk(err_n == 0, "R9 even count flags error", err_n, 0);
    @(negedge clk); a_oe_n = 1;
    load_b(8'hAA, 1'b1); a_oe_n = 0; #1;
    chk(a_out == 8'hAA && err_n == 1, "R2 parity bit stored", {a_out, err_n}, 9'h155);
    @(negedge clk); a_oe_n = 1;
    @(negedge clk); ba_ld = 1; ba_ce_n = 1; b_in = 8'h11;
    @(negedge clk); ba_ld = 0; a_oe_n = 0; #1;
    chk(a_out == 8'hAA, "R2 no load with enable high", a_out, 8'hAA);
    @(negedge clk); a_oe_n = 1;

    // R10: mid-run reset with enables high
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; #1;
    chk(ab_full == 0 && ba_full == 0, "R10 reset clears flags", {ab_full, ba_full}, 0);
    @(negedge clk); #1;
    chk(ab_full == 0 && ba_full == 0, "R10 no false edge", {ab_full, ba_full}, 0);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      a_in = $urandom; b_in = $urandom; par_in = $urandom;
      ab_ld = $urandom; ba_ld = $urandom;
      ab_ce_n = ($urandom % 4) == 0; ba_ce_n = ($urandom % 4) == 0;
      b_oe_n = $urandom; a_oe_n = $urandom;
    end
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule